// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

The block gathers peripheral interrupt sources into numbered 32-bit groups. The groups are numbered 8 through 26, and group n sits at index n-8. Each group latches the rising edges of its raw inputs into a sticky source word. A per-bit enable mask, changed only by write-one set and write-one clear registers, masks the source word, and the group exposes the masked word as a read-only result. Software clears a latched bit by writing a one to it in the source register.

A per-group block enable decides whether the OR of a group's result drives that group's aggregated line toward the processor interrupt controller. A read-only block-active word shows which groups hold at least one source bit that is both enabled and latched, whatever their block enables are. All access goes through a plain 32-bit register bus: a byte address, write data and a write strobe. Writes take effect at the clock edge, and read data is combinational.

Top module: `irq_group_aggregator`

## Requirements
- R1: Group n has its base at byte (n-8)*0x14 and holds five words: +0x0 source, +0x4 enable-set, +0x8 result, +0xC enable-clear and +0x10 reserved. The reserved word reads zero.
- R2: A rising edge on a raw input sets the matching source bit at the next clock edge. The bit stays set after the raw input falls.
- R3: Writing a 1 to a source bit clears it. Bits written as 0 keep their value.
- R4: When a rising edge and a software clear hit the same source bit in the same cycle, the bit ends up set.
- R5: Writing a 1 to an enable-set bit sets that enable bit, and writing a 1 to an enable-clear bit clears it. Bits written as 0 are unchanged. Reads of either address return the current enable mask.
- R6: The result word reads as source AND enable. A write to the result address changes neither the source nor the enable mask.
- R7: Writing a 1 to bit n at byte 0x200 sets the block enable of group n, and writing a 1 to bit n at 0x204 clears it. Both addresses read back the block-enable mask, with group n at bit n.
- R8: An aggregated line is high exactly when its group's block enable is set and its result is nonzero. Groups 8 to 21 drive lines 0 to 13, group 22 drives no line, and groups 23 to 26 drive lines 14 to 17.
- R9: At byte 0x208, bit n reads 1 when group n has a nonzero result, regardless of its block enable. All bits outside 8 to 26 read 0.
- R10: After reset every source, enable and block-enable bit is 0 and every line is low. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data |
| src_in | input | 608 | Raw sources, group index i at bits 32*i+31:32*i |
| irq_out | output | 18 | Aggregated lines toward the processor |

## Verification
A new rising edge on a raw input and a software write that clears the same source bit can land on the same clock edge. The bench provokes this in two steps. It first latches a bit and drops its input again. It then raises that input at the same negative edge on which it issues the write-one clear, so both are seen by one rising edge. The bit is judged by reading the source word afterwards, and it must still be set. The other clear tests, where no edge arrives, must show the bit cleared.

// File: rtl/iga_pkg.sv
package iga_pkg;
   localparam int GRP_WORDS   = 5;
   localparam int GRP_STRIDE  = GRP_WORDS * 4;
   localparam int BUS_W       = 32;

   typedef enum logic [2:0] {
      W_SRC = 3'd0,
      W_ENS = 3'd1,
      W_RES = 3'd2,
      W_ENC = 3'd3,
      W_RSV = 3'd4
   } grp_word_e;

   function automatic int grp_base(input int idx);
      return idx * GRP_STRIDE;
   endfunction
endpackage

// File: rtl/iga_group.sv
module iga_group
   import iga_pkg::*;
#(
   parameter int SRC_W  = 32,
   parameter int ADDR_W = 12,
   parameter int BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  raw,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              any
);
   localparam int AW = ADDR_W - 2;
   localparam logic [AW-1:0] WB = AW'(BASE / 4);
   localparam logic [AW-1:0] WE_LIM = AW'(BASE / 4 + GRP_WORDS);

   if (SRC_W > BUS_W) begin : g_bad_width
      $error("iga_group: SRC_W exceeds bus width");
   end
   if ((BASE % 4) != 0) begin : g_bad_base
      $error("iga_group: BASE must be word aligned");
   end

   logic [AW-1:0]    aw;
   logic [AW-1:0]    off;
   logic             sel;
   grp_word_e        word;
   logic [SRC_W-1:0] src_q, en_q, raw_q;
   logic [SRC_W-1:0] rise_v, clr_v, ens_v, enc_v, res_v;

   assign aw   = addr[ADDR_W-1:2];
   assign sel  = (aw >= WB) && (aw < WE_LIM);
   assign off  = aw - WB;
   assign word = grp_word_e'(off[2:0]);

   assign rise_v = raw & ~raw_q;
   assign clr_v  = (we && sel && word == W_SRC) ? wdata[SRC_W-1:0] : '0;
   assign ens_v  = (we && sel && word == W_ENS) ? wdata[SRC_W-1:0] : '0;
   assign enc_v  = (we && sel && word == W_ENC) ? wdata[SRC_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         src_q <= '0;
         en_q  <= '0;
      end else begin
         raw_q <= raw;
         src_q <= (src_q & ~clr_v) | rise_v;
         en_q  <= (en_q | ens_v) & ~enc_v;
      end
   end

   assign res_v = src_q & en_q;
   assign any   = |res_v;

   always_comb begin
      rdata = '0;
      if (sel) begin
         unique case (word)
            W_SRC:        rdata[SRC_W-1:0] = src_q;
            W_ENS, W_ENC: rdata[SRC_W-1:0] = en_q;
            W_RES:        rdata[SRC_W-1:0] = res_v;
            default:      rdata = '0;
         endcase
      end
   end

   assert_src_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(src_q) & ~$past(clr_v)) & ~src_q) == '0));

   assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(rise_v) & ~src_q) == '0));

   assert_en_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel && word == W_ENS) |=> ((en_q & $past(wdata[SRC_W-1:0])) == $past(wdata[SRC_W-1:0])));

   assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel && word == W_ENC) |=> ((en_q & $past(wdata[SRC_W-1:0])) == '0));

   assert_res_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel && word == W_RES) |=> (en_q == $past(en_q)));
endmodule

// File: rtl/iga_block_ctl.sv
module iga_block_ctl
   import iga_pkg::*;
#(
   parameter int NGRP     = 19,
   parameter int FIRST    = 8,
   parameter int ADDR_W   = 12,
   parameter int BLK_BASE = 'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [NGRP-1:0]   grp_any,
   output logic [NGRP-1:0]   blk_en,
   output logic [BUS_W-1:0]  rdata
);
   localparam int AW = ADDR_W - 2;
   localparam logic [AW-1:0] A_SET = AW'(BLK_BASE / 4);
   localparam logic [AW-1:0] A_CLR = AW'(BLK_BASE / 4 + 1);
   localparam logic [AW-1:0] A_ACT = AW'(BLK_BASE / 4 + 2);

   if (FIRST + NGRP > BUS_W) begin : g_bad_span
      $error("iga_block_ctl: group numbers exceed bus width");
   end

   logic [AW-1:0]   aw;
   logic [NGRP-1:0] set_v, clr_v;

   assign aw    = addr[ADDR_W-1:2];
   assign set_v = (we && aw == A_SET) ? wdata[FIRST +: NGRP] : '0;
   assign clr_v = (we && aw == A_CLR) ? wdata[FIRST +: NGRP] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_en <= '0;
      else        blk_en <= (blk_en | set_v) & ~clr_v;
   end

   always_comb begin
      rdata = '0;
      if (aw == A_SET || aw == A_CLR) rdata[FIRST +: NGRP] = blk_en;
      else if (aw == A_ACT)           rdata[FIRST +: NGRP] = grp_any;
   end

   assert_blk_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && aw == A_CLR) |=> ((blk_en & $past(wdata[FIRST +: NGRP])) == '0));

   assert_blk_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && aw == A_SET) |=> ((blk_en & $past(wdata[FIRST +: NGRP])) == $past(wdata[FIRST +: NGRP])));
endmodule

// File: rtl/iga_rd_mux.sv
module iga_rd_mux #(
   parameter int N = 20,
   parameter int W = 32
) (
   input  logic [N-1:0][W-1:0] din,
   output logic [W-1:0]        dout
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++) dout = dout | din[i];
   end
endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator
   import iga_pkg::*;
#(
   parameter int FIRST_GRP = 8,
   parameter int LAST_GRP  = 26,
   parameter int SKIP_GRP  = 22,
   parameter int SRC_W     = 32,
   parameter int ADDR_W    = 12,
   parameter int BLK_BASE  = 'h200,
   localparam int NGRP     = LAST_GRP - FIRST_GRP + 1,
   localparam bit HAS_SKIP = (SKIP_GRP >= FIRST_GRP) && (SKIP_GRP <= LAST_GRP),
   localparam int NLINE    = HAS_SKIP ? NGRP - 1 : NGRP
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [BUS_W-1:0]       bus_wdata,
   input  logic                   bus_we,
   output logic [BUS_W-1:0]       bus_rdata,
   input  logic [NGRP*SRC_W-1:0]  src_in,
   output logic [NLINE-1:0]       irq_out
);
   localparam int SKIP_IDX = SKIP_GRP - FIRST_GRP;

   if (grp_base(NGRP) > BLK_BASE) begin : g_bad_map
      $error("irq_group_aggregator: group space overlaps block registers");
   end
   if (BLK_BASE + 12 > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_group_aggregator: ADDR_W too small");
   end

   logic [NGRP:0][BUS_W-1:0] rd_parts;
   logic [NGRP-1:0]          grp_any;
   logic [NGRP-1:0]          blk_en;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      iga_group #(
         .SRC_W (SRC_W),
         .ADDR_W(ADDR_W),
         .BASE  (grp_base(g))
      ) u_grp (
         .clk  (clk),
         .rst_n(rst_n),
         .raw  (src_in[g*SRC_W +: SRC_W]),
         .we   (bus_we),
         .addr (bus_addr),
         .wdata(bus_wdata),
         .rdata(rd_parts[g]),
         .any  (grp_any[g])
      );
   end

   iga_block_ctl #(
      .NGRP    (NGRP),
      .FIRST   (FIRST_GRP),
      .ADDR_W  (ADDR_W),
      .BLK_BASE(BLK_BASE)
   ) u_blk (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .grp_any(grp_any),
      .blk_en (blk_en),
      .rdata  (rd_parts[NGRP])
   );

   iga_rd_mux #(.N(NGRP + 1), .W(BUS_W)) u_mux (
      .din (rd_parts),
      .dout(bus_rdata)
   );

   for (genvar l = 0; l < NLINE; l++) begin : g_line
      localparam int G = (HAS_SKIP && l >= SKIP_IDX) ? l + 1 : l;
      assign irq_out[l] = blk_en[G] & grp_any[G];

      assert_gated_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !blk_en[G] |-> !irq_out[l]);
   end
endmodule

// File: tb/tb_irq_group_aggregator.sv
module tb_irq_group_aggregator;
   localparam int NGRP = 19;
   localparam int NLINE = 18;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [11:0]          bus_addr = '0;
   logic [31:0]          bus_wdata = '0;
   logic                 bus_we = 1'b0;
   logic [31:0]          bus_rdata;
   logic [NGRP*32-1:0]   src_in = '0;
   logic [NLINE-1:0]     irq_out;

   int nvec = 0;
   int nmis = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_group_aggregator dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out)
   );

   function automatic logic [11:0] ga(input int n, input int w);
      return 12'((n - 8) * 20 + w * 4);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nmis++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #2;
      d = bus_rdata;
   endtask

   task automatic raw_set(input int n, input int b, input logic v);
      @(negedge clk);
      src_in[(n - 8) * 32 + b] = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(ga(8, 0), d);   check("R10 src after reset", d, 0);
      rd(ga(26, 1), d);  check("R10 enable after reset", d, 0);
      rd(12'h200, d);    check("R10 block enable after reset", d, 0);
      rd(12'h208, d);    check("R10 active after reset", d, 0);
      check("R10 lines after reset", 32'(irq_out), 0);
   endtask

   task automatic t_layout;
      logic [31:0] d;
      raw_set(12, 5, 1'b1);
      wr(ga(12, 1), 32'h20);
      rd(12'h050, d);    check("R1 group12 source at 0x50", d, 32'h20);
      rd(12'h054, d);    check("R1 group12 enable-set at 0x54", d, 32'h20);
      rd(12'h058, d);    check("R1 group12 result at 0x58", d, 32'h20);
      rd(12'h05C, d);    check("R1 group12 enable-clear at 0x5C", d, 32'h20);
      rd(12'h060, d);    check("R1 reserved word reads 0", d, 0);
      rd(12'h17C, d);    check("R10 unused 0x17C", d, 0);
      rd(12'h20C, d);    check("R10 unused 0x20C", d, 0);
   endtask

   task automatic t_latch;
      logic [31:0] d;
      raw_set(12, 5, 1'b0);
      rd(ga(12, 0), d);  check("R2 source sticky after raw falls", d, 32'h20);
      raw_set(13, 0, 1'b1);
      rd(ga(13, 0), d);  check("R2 edge latched in group13", d, 32'h1);
      raw_set(13, 0, 1'b0);
   endtask

   task automatic t_clear;
      logic [31:0] d;
      wr(ga(12, 0), 32'h0);
      rd(ga(12, 0), d);  check("R3 zero write keeps source", d, 32'h20);
      wr(ga(12, 0), 32'h20);
      rd(ga(12, 0), d);  check("R3 one write clears source", d, 0);
      rd(ga(12, 1), d);  check("R3 clear leaves enable", d, 32'h20);
   endtask

   task automatic t_race;
      logic [31:0] d;
      raw_set(9, 3, 1'b1);
      raw_set(9, 3, 1'b0);
      @(negedge clk);
      src_in[(9 - 8) * 32 + 3] = 1'b1;
      bus_addr = ga(9, 0); bus_wdata = 32'h8; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      rd(ga(9, 0), d);   check("R4 set wins over same-cycle clear", d, 32'h8);
      src_in[(9 - 8) * 32 + 3] = 1'b0;
      wr(ga(9, 0), 32'h8);
      rd(ga(9, 0), d);   check("R4 later clear without edge", d, 0);
   endtask

   task automatic t_enable;
      logic [31:0] d;
      wr(ga(10, 1), 32'h0F);
      wr(ga(10, 1), 32'hF0);
      rd(ga(10, 1), d);  check("R5 set accumulates", d, 32'hFF);
      wr(ga(10, 3), 32'h3C);
      rd(ga(10, 1), d);  check("R5 clear via set address read", d, 32'hC3);
      rd(ga(10, 3), d);  check("R5 clear address reads mask", d, 32'hC3);
   endtask

   task automatic t_result;
      logic [31:0] d;
      @(negedge clk);
      src_in[(10 - 8) * 32 +: 8] = 8'h5A;
      @(negedge clk);
      src_in[(10 - 8) * 32 +: 8] = 8'h00;
      rd(ga(10, 2), d);  check("R6 result is source and enable", d, 32'h42);
      wr(ga(10, 2), 32'hFFFF_FFFF);
      rd(ga(10, 0), d);  check("R6 result write keeps source", d, 32'h5A);
      rd(ga(10, 1), d);  check("R6 result write keeps enable", d, 32'hC3);
   endtask

   task automatic t_block;
      logic [31:0] d;
      rd(12'h208, d);    check("R9 active bit10 with block off", d, 32'h400);
      check("R8 line2 low with block off", 32'(irq_out[2]), 0);
      wr(12'h200, 32'h400);
      rd(12'h204, d);    check("R7 block mask read", d, 32'h400);
      check("R8 line2 high with block on", 32'(irq_out[2]), 1);
      wr(12'h204, 32'h400);
      rd(12'h200, d);    check("R7 block clear", d, 0);
      check("R8 line2 low after block clear", 32'(irq_out[2]), 0);
      // group 22 has no line
      raw_set(22, 1, 1'b1);
      wr(ga(22, 1), 32'h2);
      wr(12'h200, 32'h0040_0000);
      check("R8 group22 drives no line", 32'(irq_out), 0);
      rd(12'h208, d);    check("R9 active shows 10 and 22", d, 32'h0040_0400);
      // group 23 -> line 14, group 26 -> line 17, group 21 -> line 13
      raw_set(23, 0, 1'b1);
      wr(ga(23, 1), 32'h1);
      wr(12'h200, 32'h0080_0000);
      check("R8 group23 on line14", 32'(irq_out), 32'h4000);
      raw_set(26, 31, 1'b1);
      wr(ga(26, 1), 32'h8000_0000);
      wr(12'h200, 32'h0400_0000);
      check("R8 group26 on line17", 32'(irq_out), 32'h24000);
      raw_set(21, 2, 1'b1);
      wr(ga(21, 1), 32'h4);
      wr(12'h200, 32'h0020_0000);
      check("R8 group21 on line13", 32'(irq_out), 32'h26000);
      rd(12'h208, d);
      check("R9 active only group bits", d & ~32'h07FF_FF00, 0);
      check("R9 active set", d, 32'h04E0_0400);
      wr(ga(26, 3), 32'h8000_0000);
      check("R8 enable clear drops line17", 32'(irq_out), 32'h6000);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         nmis++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_layout;
      t_latch;
      t_clear;
      t_race;
      t_enable;
      t_result;
      t_block;
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
         $finish;
      end
   end
endmodule